// File: doc/BRIEF.md
# Input Sample Error Detector

This block watches a stream of 16-bit input samples, one per clock, and compares each word with a programmed test pattern. The pattern has four words that always repeat in the order I0, Q0, I1, Q1. A rising edge on the frame strobe marks the word on the bus as I0, which aligns the pattern. A byte-wide host port loads the four expected words, turns the checker on, selects autoclear behaviour, clears the latched results and sets an interrupt mask.

The block keeps three results. A sticky error flag records any mismatch until the host clears it. Two 16-bit accumulators record which bit positions have ever mismatched: one covers the I words and the other covers the Q words. In autoclear mode there are also live pass and fail flags. In that mode a run of eight clean comparisons in a row drops the fail flag and empties both accumulators, while the sticky flag stays set. Any flag allowed by the mask drives the interrupt line.

Top module: `smp_err_det`

## Requirements
- R1: After reset, every register reads 0, the status flags and interrupt are low, and both accumulators are zero.
- R2: The expected words are loaded at addresses 0x1 to 0x8, low byte then high byte, in the word order I0, Q0, I1, Q1. Every byte reads back at the address it was written to.
- R3: A rising edge on `smp_frame` makes the current word I0, and later words follow in the order Q0, I1, Q1 and then repeat. A new rising edge at any point realigns the order to I0. Holding the strobe high has no further effect.
- R4: No comparison happens while the enable bit (bit 7 of the control/status register at 0x0) is clear. After enabling, no comparison happens until a frame edge has been seen.
- R5: Status bit 5, the sticky error flag, sets on any mismatch. It stays set until the host writes 0x0 with bit 5 = 1, and autoclear never changes it.
- R6: Mismatching bits of I0 and I1 are OR-ed into the I accumulator, read at 0xA (low byte) and 0xB (high byte). Mismatching bits of Q0 and Q1 are OR-ed into the Q accumulator, read at 0xC and 0xD.
- R7: A clear write resets the sticky flag and both accumulators at the same edge. If a mismatch occurs in that same cycle, the mismatch wins and is recorded.
- R8: Status bits 1 (fail) and 0 (pass) read 0 unless autoclear (control bit 6) is set. In autoclear mode, pass shows whether the latest comparison was clean, and fail sets on any mismatch.
- R9: In autoclear mode, the eighth clean comparison in a row clears fail and zeroes both accumulators. Fewer clean comparisons leave them unchanged, and a mismatch restarts the run.
- R10: `irq` is high when any flag is set whose mask bit is set. The mask register is at 0x9, and its bits 5, 1 and 0 enable the sticky, fail and pass flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | 16 | Incoming sample word |
| smp_frame | input | 1 | Alignment strobe; its rising edge marks I0 |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for `host_addr` |
| err_sticky | output | 1 | Sticky error flag |
| cmp_fail | output | 1 | Autoclear fail flag |
| cmp_pass | output | 1 | Autoclear pass flag |
| irq | output | 1 | Masked interrupt |

## Verification
A sample and a host write both take effect at the rising edge that captures them. The flags, accumulators and `irq` therefore change one edge after the stimulus, and register reads are combinational from the address. The bench drives each stimulus at the falling edge, waits for the next rising edge, and samples shortly after it. All reads finish before the next falling edge, so every result is checked in the first cycle it is due. A sweep places a single-bit error at each of the 16 bit positions in each of the four pattern slots, and checks the sticky flag and the correct accumulator against values the bench computes.

// File: rtl/smp_err_pkg.sv
// Package: constants shared by the sample error detector.
// Assumes a four-word pattern (I0, Q0, I1, Q1) and byte-wide host registers.
package smp_err_pkg;
    localparam int SMP_W     = 16;
    localparam int N_WORDS   = 4;
    localparam int ADDR_CTRL = 0;
    localparam int CMP_BASE  = 1;
    localparam int BIT_EN    = 7;
    localparam int BIT_AC    = 6;
    localparam int BIT_ERR   = 5;
    localparam int BIT_FAIL  = 1;
    localparam int BIT_PASS  = 0;
    localparam int CLEAN_RUN = 8;
endpackage

// File: rtl/smp_err_regs.sv
// Host register file: control, expected words, interrupt mask, read mux.
// Assumes single-cycle byte writes and a combinational read of host_addr.
module smp_err_regs
    import smp_err_pkg::*;
#(
    parameter int W  = SMP_W,
    parameter int AW = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [AW-1:0]               host_addr,
    input  logic [7:0]                  host_wdata,
    input  logic                        sticky,
    input  logic                        fail,
    input  logic                        pass,
    input  logic [W-1:0]                acc_i,
    input  logic [W-1:0]                acc_q,
    output logic [7:0]                  host_rdata,
    output logic                        enable,
    output logic                        autoclr,
    output logic                        clr_strb,
    output logic [2:0]                  irq_mask,
    output logic [N_WORDS-1:0][W-1:0]   cmp_words
);
    localparam int BYTES     = W / 8;
    localparam int N_BYTES   = N_WORDS * BYTES;
    localparam int ADDR_MASK = CMP_BASE + N_BYTES;
    localparam int ACC_I     = ADDR_MASK + 1;
    localparam int ACC_Q     = ACC_I + BYTES;

    logic [7:0] cmp_bytes [N_BYTES];

    // Clear strobe: write to control with the error bit set.
    assign clr_strb = host_we && (host_addr == AW'(ADDR_CTRL)) && host_wdata[BIT_ERR];

    // Host writes into control, mask and expected-word bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            autoclr  <= 1'b0;
            irq_mask <= '0;
            for (int i = 0; i < N_BYTES; i++) cmp_bytes[i] <= '0;
        end else if (host_we) begin
            if (host_addr == AW'(ADDR_CTRL)) begin
                enable  <= host_wdata[BIT_EN];
                autoclr <= host_wdata[BIT_AC];
            end
            if (host_addr == AW'(ADDR_MASK))
                irq_mask <= {host_wdata[BIT_ERR], host_wdata[BIT_FAIL], host_wdata[BIT_PASS]};
            for (int i = 0; i < N_BYTES; i++)
                if (host_addr == AW'(CMP_BASE + i)) cmp_bytes[i] <= host_wdata;
        end
    end

    // Assemble expected words from their bytes, low byte first.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign cmp_words[w][b*8 +: 8] = cmp_bytes[w*BYTES + b];
        end
    end

    // Read mux over every host-visible register.
    always_comb begin
        host_rdata = '0;
        if (host_addr == AW'(ADDR_CTRL)) begin
            host_rdata[BIT_EN]   = enable;
            host_rdata[BIT_AC]   = autoclr;
            host_rdata[BIT_ERR]  = sticky;
            host_rdata[BIT_FAIL] = fail;
            host_rdata[BIT_PASS] = pass;
        end
        if (host_addr == AW'(ADDR_MASK)) begin
            host_rdata[BIT_ERR]  = irq_mask[2];
            host_rdata[BIT_FAIL] = irq_mask[1];
            host_rdata[BIT_PASS] = irq_mask[0];
        end
        for (int i = 0; i < N_BYTES; i++)
            if (host_addr == AW'(CMP_BASE + i)) host_rdata = cmp_bytes[i];
        for (int b = 0; b < BYTES; b++) begin
            if (host_addr == AW'(ACC_I + b)) host_rdata = acc_i[b*8 +: 8];
            if (host_addr == AW'(ACC_Q + b)) host_rdata = acc_q[b*8 +: 8];
        end
    end
endmodule

// File: rtl/smp_err_cmp.sv
// Pattern phase tracking and word comparison.
// Assumes one sample per clock; a frame rising edge marks the current word as I0.
module smp_err_cmp
    import smp_err_pkg::*;
#(
    parameter int W = SMP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       smp_frame,
    input  logic [W-1:0]               smp_data,
    input  logic [N_WORDS-1:0][W-1:0]  cmp_words,
    output logic                       valid,
    output logic                       mismatch,
    output logic                       is_q,
    output logic [W-1:0]               diff
);
    localparam int PH_W = $clog2(N_WORDS);

    logic            frame_q;
    logic            aligned_q;
    logic [PH_W-1:0] phase_q;
    logic            rise;
    logic [PH_W-1:0] idx;

    // Combinational compare of the current word against its slot.
    always_comb begin
        rise     = smp_frame && !frame_q;
        idx      = rise ? '0 : phase_q;
        valid    = enable && (rise || aligned_q);
        diff     = valid ? (smp_data ^ cmp_words[idx]) : '0;
        mismatch = |diff;
        is_q     = idx[0];
    end

    // Track frame edge, alignment and the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= 1'b0;
            aligned_q <= 1'b0;
            phase_q   <= '0;
        end else begin
            frame_q   <= smp_frame;
            aligned_q <= enable && (aligned_q || rise);
            phase_q   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/smp_err_flags.sv
// Result state: sticky flag, pass/fail, clean-run counter, bit accumulators.
// Assumes diff is zero when no comparison is made in the cycle.
module smp_err_flags
    import smp_err_pkg::*;
#(
    parameter int W   = SMP_W,
    parameter int RUN = CLEAN_RUN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         autoclr,
    input  logic         clr_strb,
    input  logic         valid,
    input  logic         mismatch,
    input  logic         is_q,
    input  logic [W-1:0] diff,
    output logic         sticky,
    output logic         fail,
    output logic         pass,
    output logic [W-1:0] acc_i,
    output logic [W-1:0] acc_q
);
    localparam int CNT_W = $clog2(RUN);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN - 1);

    logic [CNT_W-1:0] clean_cnt;
    logic             wipe;

    // Last clean comparison of a full run while autoclear is on.
    assign wipe = autoclr && valid && !mismatch && (clean_cnt == CNT_MAX);

    // Saturating count of consecutive clean comparisons.
    always_ff @(posedge clk) begin
        if (!rst_n)                clean_cnt <= '0;
        else if (valid && mismatch) clean_cnt <= '0;
        else if (valid && clean_cnt != CNT_MAX) clean_cnt <= clean_cnt + 1'b1;
    end

    // Sticky flag and accumulators; a new error outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            acc_i  <= '0;
            acc_q  <= '0;
        end else begin
            sticky <= mismatch || (sticky && !clr_strb);
            acc_i  <= ((clr_strb || wipe) ? '0 : acc_i) | (is_q ? '0 : diff);
            acc_q  <= ((clr_strb || wipe) ? '0 : acc_q) | (is_q ? diff : '0);
        end
    end

    // Live pass/fail flags, active only under autoclear.
    always_ff @(posedge clk) begin
        if (!rst_n || !autoclr) begin
            pass <= 1'b0;
            fail <= 1'b0;
        end else begin
            if (valid) pass <= !mismatch;
            if (mismatch)  fail <= 1'b1;
            else if (wipe) fail <= 1'b0;
        end
    end
endmodule

// File: rtl/smp_err_det.sv
// Top: input sample error detector with host registers and masked interrupt.
// Assumes one 16-bit sample per clock and a synchronous active-low reset.
module smp_err_det
    import smp_err_pkg::*;
#(
    parameter int W  = SMP_W,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  smp_data,
    input  logic          smp_frame,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          err_sticky,
    output logic          cmp_fail,
    output logic          cmp_pass,
    output logic          irq
);
    logic                      enable, autoclr, clr_strb;
    logic [2:0]                irq_mask;
    logic [N_WORDS-1:0][W-1:0] cmp_words;
    logic                      valid, mismatch, is_q;
    logic [W-1:0]              diff, acc_i, acc_q;
    logic                      sticky, fail, pass;

    smp_err_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .sticky(sticky), .fail(fail), .pass(pass),
        .acc_i(acc_i), .acc_q(acc_q), .host_rdata(host_rdata), .enable(enable),
        .autoclr(autoclr), .clr_strb(clr_strb), .irq_mask(irq_mask),
        .cmp_words(cmp_words)
    );

    smp_err_cmp #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_frame(smp_frame),
        .smp_data(smp_data), .cmp_words(cmp_words), .valid(valid),
        .mismatch(mismatch), .is_q(is_q), .diff(diff)
    );

    smp_err_flags #(.W(W)) u_flags (
        .clk(clk), .rst_n(rst_n), .autoclr(autoclr), .clr_strb(clr_strb),
        .valid(valid), .mismatch(mismatch), .is_q(is_q), .diff(diff),
        .sticky(sticky), .fail(fail), .pass(pass), .acc_i(acc_i), .acc_q(acc_q)
    );

    // Outputs: flags and masked interrupt.
    assign err_sticky = sticky;
    assign cmp_fail   = fail;
    assign cmp_pass   = pass;
    assign irq        = |(irq_mask & {sticky, fail, pass});
endmodule

// File: rtl/smp_err_det_chk.sv
// Checker: temporal properties of the sample error detector, bound to the top.
// Assumes it sees the top's internal control and result signals.
module smp_err_det_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         autoclr,
    input logic         clr_strb,
    input logic         mismatch,
    input logic         sticky,
    input logic         fail,
    input logic         pass,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] acc_q
);
    AST_NO_CMP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !mismatch); // R4
    AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> sticky); // R5
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sticky && !clr_strb |=> sticky); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strb && !mismatch |=> (acc_i == '0) && (acc_q == '0)); // R7
    AST_LIVE_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !autoclr |=> !fail && !pass); // R8
    AST_FAIL_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch && autoclr |=> fail); // R8
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) && $past(autoclr) |-> (acc_i == '0) && (acc_q == '0)); // R9
endmodule

bind smp_err_det smp_err_det_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .autoclr(autoclr),
    .clr_strb(clr_strb), .mismatch(mismatch), .sticky(sticky), .fail(fail),
    .pass(pass), .acc_i(acc_i), .acc_q(acc_q)
);

// File: tb/smp_err_det_tb.sv
`timescale 1ns/100ps
// Bench: drives samples and host writes, and compares against a model built from the requirements.
module smp_err_det_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_frame = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        err_sticky, cmp_fail, cmp_pass, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state.
    logic [15:0] m_cmp [4];
    logic        m_en = 0, m_ac = 0, m_al = 0, m_fq = 0;
    logic        m_st = 0, m_fl = 0, m_ps = 0;
    logic [15:0] m_ai = '0, m_aq = '0;
    logic [2:0]  m_mask = '0;
    int          m_ph = 0, m_cnt = 0;

    always #4 clk = ~clk;

    smp_err_det dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_frame(smp_frame),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .err_sticky(err_sticky), .cmp_fail(cmp_fail),
        .cmp_pass(cmp_pass), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_addr = a;
        #0.2;
        d = host_rdata;
    endtask

    // One clock: drive a sample (expected word XOR err) and an optional write.
    task automatic tick(input logic [15:0] err, input logic frm, input logic we,
                        input logic [3:0] a, input logic [7:0] wd);
        logic rise, valid, mism, clr, wipe;
        int ph;
        @(negedge clk);
        rise  = frm && !m_fq;
        ph    = rise ? 0 : m_ph;
        valid = m_en && (rise || m_al);
        smp_data = m_cmp[ph] ^ err; smp_frame = frm;
        host_we = we; host_addr = a; host_wdata = wd;
        mism = valid && (err != 0);
        clr  = we && (a == 4'h0) && wd[5];
        wipe = m_ac && valid && !mism && (m_cnt == 7);
        m_st = mism || (m_st && !clr);
        if (clr || wipe) begin m_ai = '0; m_aq = '0; end
        if (valid) begin
            if (ph % 2 == 0) m_ai = m_ai | err; else m_aq = m_aq | err;
        end
        if (!m_ac) begin m_ps = 0; m_fl = 0; end
        else begin
            if (valid) m_ps = !mism;
            if (mism) m_fl = 1; else if (wipe) m_fl = 0;
        end
        if (valid) m_cnt = mism ? 0 : ((m_cnt == 7) ? 7 : m_cnt + 1);
        m_al = m_en && (m_al || rise);
        m_fq = frm;
        m_ph = (ph + 1) % 4;
        if (we) begin
            if (a == 4'h0) begin m_en = wd[7]; m_ac = wd[6]; end
            else if (a >= 4'h1 && a <= 4'h8) begin
                if ((a - 1) % 2 == 0) m_cmp[(a-1)/2][7:0] = wd;
                else                  m_cmp[(a-1)/2][15:8] = wd;
            end else if (a == 4'h9) m_mask = {wd[5], wd[1], wd[0]};
        end
        @(posedge clk);
        #0.1;
        host_we = 1'b0;
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++) tick('0, 1'b0, 1'b0, 4'h0, 8'h00);
    endtask

    // Compare status, accumulators, flag ports and interrupt with the model.
    task automatic check_all(input string req);
        logic [7:0] d;
        rd(4'h0, d); chk(req, {8'h0, d}, {8'h0, m_en, m_ac, m_st, 3'b000, m_fl, m_ps});
        rd(4'hA, d); chk(req, {8'h0, d}, {8'h0, m_ai[7:0]});
        rd(4'hB, d); chk(req, {8'h0, d}, {8'h0, m_ai[15:8]});
        rd(4'hC, d); chk(req, {8'h0, d}, {8'h0, m_aq[7:0]});
        rd(4'hD, d); chk(req, {8'h0, d}, {8'h0, m_aq[15:8]});
        chk(req, {13'h0, err_sticky, cmp_fail, cmp_pass}, {13'h0, m_st, m_fl, m_ps});
        chk(req, {15'h0, irq}, {15'h0, |({m_st, m_fl, m_ps} & m_mask)});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.1;
        check_all("R1");
        for (int a = 1; a < 10; a++) begin rd(4'(a), d); chk("R1", {8'h0, d}, 16'h0); end

        // R2: load distinct expected words and read every byte back.
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'hA5C3 ^ (16'(k) * 16'h1F2D);
            tick('0, 1'b0, 1'b1, 4'(1 + 2*k), v[7:0]);
            tick('0, 1'b0, 1'b1, 4'(2 + 2*k), v[15:8]);
        end
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'hA5C3 ^ (16'(k) * 16'h1F2D);
            rd(4'(1 + 2*k), d); chk("R2", {8'h0, d}, {8'h0, v[7:0]});
            rd(4'(2 + 2*k), d); chk("R2", {8'h0, d}, {8'h0, v[15:8]});
        end

        // R4: errors while disabled, then enabled but not yet framed.
        tick(16'hFFFF, 1'b1, 1'b0, 4'h0, 8'h00);
        tick(16'hFFFF, 1'b0, 1'b0, 4'h0, 8'h00);
        check_all("R4");
        tick('0, 1'b0, 1'b1, 4'h0, 8'h80);
        tick(16'hFFFF, 1'b0, 1'b0, 4'h0, 8'h00);
        tick(16'h00F0, 1'b0, 1'b0, 4'h0, 8'h00);
        check_all("R4");

        // R3/R5/R6: single-bit error in every slot at every bit position.
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] e;
                e = 16'(1) << b;
                tick('0, 1'b0, 1'b1, 4'h0, 8'hA0);
                if (b % 3 == 1) clean(1);
                tick((p == 0) ? e : '0, 1'b1, 1'b0, 4'h0, 8'h00);
                for (int k = 1; k < 4; k++) tick((p == k) ? e : '0, 1'b0, 1'b0, 4'h0, 8'h00);
                check_all("R6");
                rd((p % 2 == 0) ? ((b < 8) ? 4'hA : 4'hB) : ((b < 8) ? 4'hC : 4'hD), d);
                chk("R3", {8'h0, d}, {8'h0, 8'(1 << (b % 8))});
                chk("R5", {15'h0, err_sticky}, 16'h1);
            end
        end

        // R3: frame held for two samples marks I0 once; second word is Q0.
        tick('0, 1'b0, 1'b1, 4'h0, 8'hA0);
        tick('0, 1'b1, 1'b0, 4'h0, 8'h00);
        tick(16'h8000, 1'b1, 1'b0, 4'h0, 8'h00);
        check_all("R3");
        rd(4'hD, d); chk("R3", {8'h0, d}, 16'h0080);

        // R7: clear together with an error, then a plain clear.
        clean(2);
        tick(16'h0100, 1'b0, 1'b1, 4'h0, 8'hA0);
        check_all("R7");
        tick('0, 1'b0, 1'b1, 4'h0, 8'hA0);
        check_all("R7");
        clean(3);
        check_all("R5");

        // R8/R9: autoclear behaviour.
        tick('0, 1'b0, 1'b1, 4'h0, 8'hE0);
        check_all("R8");
        tick(16'h0003, 1'b0, 1'b0, 4'h0, 8'h00);
        check_all("R8");
        for (int i = 0; i < 7; i++) begin clean(1); check_all("R9"); end
        clean(1);
        check_all("R9");
        chk("R9", {14'h0, cmp_fail, err_sticky}, 16'h0001);
        tick(16'h4000, 1'b0, 1'b0, 4'h0, 8'h00);
        clean(4);
        tick(16'h0020, 1'b0, 1'b0, 4'h0, 8'h00);
        clean(7);
        check_all("R9");
        clean(1);
        check_all("R9");

        // R10: every mask value with pass set, then with fail and pass set.
        for (int m = 0; m < 8; m++) begin
            tick('0, 1'b0, 1'b1, 4'h9, {2'b00, m[2], 3'b000, m[1], m[0]});
            check_all("R10");
            rd(4'h9, d); chk("R10", {8'h0, d}, {8'h0, 2'b00, m[2], 3'b000, m[1], m[0]});
        end
        tick(16'h0001, 1'b0, 1'b0, 4'h0, 8'h00);
        clean(1);
        for (int m = 0; m < 8; m++) begin
            tick('0, 1'b0, 1'b1, 4'h9, {2'b00, m[2], 3'b000, m[1], m[0]});
            check_all("R10");
        end

        // R8: leaving autoclear drops pass and fail.
        tick('0, 1'b0, 1'b1, 4'h0, 8'h80);
        check_all("R8");
        tick(16'h0002, 1'b0, 1'b0, 4'h0, 8'h00);
        check_all("R8");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule